// File: doc/BRIEF.md
# PWM Fault Protection Channel

This block guards the outputs of a PWM generator against external fault signals. It handles one to four fault inputs. Each input has its own active level and passes through a sampled glitch filter. When the filtered signal becomes active, the block sets a sticky flag and holds that channel's output-disable line asserted. Software clears the flags by writing ones to them. An interrupt request is raised for every flag whose enable bit is set.

Each channel releases its disable line in one of three ways. Automatic clearing releases once the filtered fault goes inactive. Plain manual clearing releases once software has cleared the flag. Safe manual clearing needs both the flag cleared and the input inactive. In every mode the release happens only on a cycle boundary chosen per channel: a half-cycle tick, a full-cycle tick, either tick, or never. A channel can also let its raw, unfiltered input drive the disable line directly, so protection starts in the same cycle the pin changes.

Each channel runs a three-state machine. The states are CLEAR (outputs enabled), HELD (fault latched, waiting for the clear condition) and ARMED (clear condition met, waiting for the selected boundary). The transitions are:
- CLEAR→HELD on a filtered fault onset.
- HELD→ARMED when the release condition holds and no new onset arrives.
- ARMED→HELD when the condition is lost or a new onset arrives.
- ARMED→CLEAR on a selected boundary tick.

Top module: `pwm_fault_guard`

## Requirements
- R1: A channel's input counts as active when it equals that channel's `flt_pol` bit (1 = high means fault, 0 = low means fault).
- R2: With `filt_per` = 0 the filter is bypassed. The filtered level equals the active level one clock earlier, and the filter's sample counters are held cleared.
- R3: With `filt_per` ≠ 0, one sample is taken every `filt_per` clocks. A new level is accepted only after `filt_cnt`+3 consecutive samples all differ from the current filtered level. Any agreeing sample restarts the count.
- R4: A channel's flag is set in the clock after its filtered level rises to active. A one on `flag_clr` clears the flag. An onset in the same cycle as a clear wins.
- R5: `irq` is high exactly when some channel has both its flag and its `irq_en` bit set.
- R6: With `flt_auto` = 1, a channel becomes eligible for release once its filtered fault is inactive, whatever its flag holds.
- R7: With `flt_auto` = 0 and `flt_safe` = 0, a channel becomes eligible for release once its flag is clear, even while the input is still active.
- R8: With `flt_auto` = 0 and `flt_safe` = 1, a channel becomes eligible for release only when its flag is clear and its filtered fault is inactive.
- R9: An eligible channel deasserts `out_dis` only in the clock after a `half_tick` (when `rcv_half` = 1) or a `full_tick` (when `rcv_full` = 1).
- R10: With `rcv_half` = `rcv_full` = 0, a latched channel stays disabled until a recovery bit is set again or reset is applied.
- R11: With `raw_en` = 1, an active raw input asserts `out_dis` in the same cycle, without waiting for the filter or the latch.
- R12: After reset, all flags, `irq` and all `out_dis` lines are low while the inputs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_in | input | N_FLT | Raw fault inputs |
| flt_pol | input | N_FLT | Active level per input |
| flt_auto | input | N_FLT | 1 selects automatic clearing |
| flt_safe | input | N_FLT | Safety option for manual clearing |
| raw_en | input | N_FLT | 1 lets the raw input disable outputs directly |
| rcv_half | input | N_FLT | Release on half-cycle tick |
| rcv_full | input | N_FLT | Release on full-cycle tick |
| filt_cnt | input | CNT_W | Filter sample count (accept after count+3) |
| filt_per | input | PER_W | Filter sample period in clocks, 0 bypasses |
| half_tick | input | 1 | Half-cycle boundary pulse from the PWM counter |
| full_tick | input | 1 | Full-cycle boundary pulse from the PWM counter |
| flag_clr | input | N_FLT | Write-one-to-clear pulses for the flags |
| irq_en | input | N_FLT | Interrupt enable per flag |
| out_dis | output | N_FLT | Output-disable per input |
| flt_flag | output | N_FLT | Sticky fault flags |
| irq | output | 1 | Interrupt request |

## Verification
A channel stuck in the wrong state shows up on `out_dis` at the next boundary tick. A channel that releases early or stays latched differs there within one PWM half cycle. A flag that is lost or set twice shows on `flt_flag` and `irq` one clock after the filtered edge. A miscounting filter shifts that edge by whole sample periods. A bench model that steps every clock compares all three outputs each cycle, under random modes, clears and inputs. Directed cases pin down the safe, no-recovery and raw-path corners.

// File: rtl/pwm_flt_pkg.sv
package pwm_flt_pkg;
    typedef enum logic [1:0] {
        FS_CLEAR = 2'd0,
        FS_HELD  = 2'd1,
        FS_ARMED = 2'd2
    } flt_state_e;
endpackage

// File: rtl/pwm_flt_filter.sv
module pwm_flt_filter #(
    parameter int CNT_W = 3,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic [CNT_W-1:0] cnt,
    input  logic [PER_W-1:0] per,
    output logic             filt,
    output logic             rise
);
    localparam int DC_W = CNT_W + 1;

    logic [PER_W-1:0] pcnt_q;
    logic [DC_W-1:0]  dcnt_q;
    logic [DC_W-1:0]  dlim;
    logic             bypass;
    logic             sample;

    assign bypass = (per == '0);
    assign sample = (pcnt_q == per - 1'b1);
    assign dlim   = {1'b0, cnt} + DC_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            dcnt_q <= '0;
            filt   <= 1'b0;
            rise   <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (bypass) begin
                pcnt_q <= '0;
                dcnt_q <= '0;
                filt   <= act;
                rise   <= act & ~filt;
            end else if (sample) begin
                pcnt_q <= '0;
                if (act == filt) begin
                    dcnt_q <= '0;
                end else if (dcnt_q == dlim) begin
                    dcnt_q <= '0;
                    filt   <= act;
                    rise   <= act;
                end else begin
                    dcnt_q <= dcnt_q + 1'b1;
                end
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_flt_latch.sv
module pwm_flt_latch
    import pwm_flt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic filt,
    input  logic rise,
    input  logic auto_clr,
    input  logic safe,
    input  logic rcv_half,
    input  logic rcv_full,
    input  logic half_tick,
    input  logic full_tick,
    input  logic clr,
    output logic flag,
    output logic latched
);
    flt_state_e st_q, st_d;
    logic       rel_ok;
    logic       boundary;

    always_comb begin
        if (auto_clr)  rel_ok = ~filt;
        else if (safe) rel_ok = ~flag & ~filt;
        else           rel_ok = ~flag;
    end

    assign boundary = (half_tick & rcv_half) | (full_tick & rcv_full);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_CLEAR: if (rise) st_d = FS_HELD;
            FS_HELD:  if (rel_ok && !rise) st_d = FS_ARMED;
            FS_ARMED: begin
                if (rise || !rel_ok) st_d = FS_HELD;
                else if (boundary)   st_d = FS_CLEAR;
            end
            default:  st_d = FS_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_CLEAR;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= rise | (flag & ~clr);
    end

    always_comb begin
        latched = (st_q != FS_CLEAR);
    end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
    parameter int N_FLT = 2,
    parameter int CNT_W = 3,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_FLT-1:0] flt_in,
    input  logic [N_FLT-1:0] flt_pol,
    input  logic [N_FLT-1:0] flt_auto,
    input  logic [N_FLT-1:0] flt_safe,
    input  logic [N_FLT-1:0] raw_en,
    input  logic [N_FLT-1:0] rcv_half,
    input  logic [N_FLT-1:0] rcv_full,
    input  logic [CNT_W-1:0] filt_cnt,
    input  logic [PER_W-1:0] filt_per,
    input  logic             half_tick,
    input  logic             full_tick,
    input  logic [N_FLT-1:0] flag_clr,
    input  logic [N_FLT-1:0] irq_en,
    output logic [N_FLT-1:0] out_dis,
    output logic [N_FLT-1:0] flt_flag,
    output logic             irq
);
    logic [N_FLT-1:0] act_vec;
    logic [N_FLT-1:0] filt_vec;
    logic [N_FLT-1:0] rise_vec;
    logic [N_FLT-1:0] latched_vec;

    for (genvar g = 0; g < N_FLT; g++) begin : g_ch
        assign act_vec[g] = flt_pol[g] ? flt_in[g] : ~flt_in[g];

        pwm_flt_filter #(.CNT_W(CNT_W), .PER_W(PER_W)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .act  (act_vec[g]),
            .cnt  (filt_cnt),
            .per  (filt_per),
            .filt (filt_vec[g]),
            .rise (rise_vec[g])
        );

        pwm_flt_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .filt     (filt_vec[g]),
            .rise     (rise_vec[g]),
            .auto_clr (flt_auto[g]),
            .safe     (flt_safe[g]),
            .rcv_half (rcv_half[g]),
            .rcv_full (rcv_full[g]),
            .half_tick(half_tick),
            .full_tick(full_tick),
            .clr      (flag_clr[g]),
            .flag     (flt_flag[g]),
            .latched  (latched_vec[g])
        );

        assign out_dis[g] = latched_vec[g] | (raw_en[g] & act_vec[g]);
    end

    assign irq = |(flt_flag & irq_en);
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
    parameter int N_FLT = 2,
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_FLT-1:0] flt_in,
    input logic [N_FLT-1:0] flt_pol,
    input logic [N_FLT-1:0] flt_auto,
    input logic [N_FLT-1:0] flt_safe,
    input logic [N_FLT-1:0] raw_en,
    input logic [N_FLT-1:0] rcv_half,
    input logic [N_FLT-1:0] rcv_full,
    input logic [PER_W-1:0] filt_per,
    input logic             half_tick,
    input logic             full_tick,
    input logic [N_FLT-1:0] flag_clr,
    input logic [N_FLT-1:0] filt_vec,
    input logic [N_FLT-1:0] rise_vec,
    input logic [N_FLT-1:0] latched_vec,
    input logic [N_FLT-1:0] flt_flag,
    input logic [N_FLT-1:0] out_dis
);
    for (genvar i = 0; i < N_FLT; i++) begin : g_a
        AST_RAW_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_en[i] && (flt_in[i] == flt_pol[i])) |-> out_dis[i]); // R11
        AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_vec[i] |=> flt_flag[i]); // R4
        AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_flag[i] && flag_clr[i] && !rise_vec[i]) |=> !flt_flag[i]); // R4
        AST_FILTER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_per == '0) |=> (filt_vec[i] == $past(flt_in[i] == flt_pol[i]))); // R2
        AST_BOUNDARY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(latched_vec[i]) |-> $past((half_tick && rcv_half[i]) || (full_tick && rcv_full[i]))); // R9
        AST_NO_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
            (latched_vec[i] && !rcv_half[i] && !rcv_full[i]) |=> latched_vec[i]); // R10
        AST_SAFE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(latched_vec[i]) |-> $past(flt_auto[i] || !flt_safe[i] || (!flt_flag[i] && !filt_vec[i]))); // R8
        AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(latched_vec[i]) && $past(flt_auto[i])) |-> $past(!filt_vec[i])); // R6
    end
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.N_FLT(N_FLT), .PER_W(PER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_in     (flt_in),
    .flt_pol    (flt_pol),
    .flt_auto   (flt_auto),
    .flt_safe   (flt_safe),
    .raw_en     (raw_en),
    .rcv_half   (rcv_half),
    .rcv_full   (rcv_full),
    .filt_per   (filt_per),
    .half_tick  (half_tick),
    .full_tick  (full_tick),
    .flag_clr   (flag_clr),
    .filt_vec   (filt_vec),
    .rise_vec   (rise_vec),
    .latched_vec(latched_vec),
    .flt_flag   (flt_flag),
    .out_dis    (out_dis)
);

// File: tb/pwm_fault_guard_tb.sv
module pwm_fault_guard_tb;
    localparam int N = 2;
    localparam int CW = 3;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  flt_in = '0, flt_pol = '1, flt_auto = '1, flt_safe = '0;
    logic [N-1:0]  raw_en = '0, rcv_half = '0, rcv_full = '1, flag_clr = '0, irq_en = '0;
    logic [CW-1:0] filt_cnt = '0;
    logic [PW-1:0] filt_per = '0;
    logic          half_tick = 1'b0, full_tick = 1'b0;
    logic [N-1:0]  out_dis, flt_flag;
    logic          irq;

    int    n_chk = 0, n_err = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string phase = "R12";

    int m_st[N], m_pc[N], m_dc[N];
    bit m_filt[N], m_rise[N], m_flag[N];
    int tcnt = 0;

    pwm_fault_guard #(.N_FLT(N), .CNT_W(CW), .PER_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flt_in(flt_in), .flt_pol(flt_pol),
        .flt_auto(flt_auto), .flt_safe(flt_safe), .raw_en(raw_en),
        .rcv_half(rcv_half), .rcv_full(rcv_full), .filt_cnt(filt_cnt),
        .filt_per(filt_per), .half_tick(half_tick), .full_tick(full_tick),
        .flag_clr(flag_clr), .irq_en(irq_en), .out_dis(out_dis),
        .flt_flag(flt_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic bit act_of(int i);
        return flt_pol[i] ? flt_in[i] : !flt_in[i];
    endfunction

    function automatic bit rel_of(int i);
        if (flt_auto[i]) return !m_filt[i];
        if (flt_safe[i]) return !m_flag[i] && !m_filt[i];
        return !m_flag[i];
    endfunction

    // reference model, stepped on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_pc[i] = 0; m_dc[i] = 0;
                m_filt[i] = 0; m_rise[i] = 0; m_flag[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                bit a, rel, bnd, nf, nr;
                int ns;
                a = act_of(i);
                rel = rel_of(i);
                bnd = (half_tick && rcv_half[i]) || (full_tick && rcv_full[i]);
                ns = m_st[i];
                if (m_st[i] == 0 && m_rise[i]) ns = 1;
                else if (m_st[i] == 1 && rel && !m_rise[i]) ns = 2;
                else if (m_st[i] == 2) begin
                    if (m_rise[i] || !rel) ns = 1;
                    else if (bnd) ns = 0;
                end
                m_st[i] = ns;
                m_flag[i] = m_rise[i] || (m_flag[i] && !flag_clr[i]);
                nf = m_filt[i]; nr = 0;
                if (filt_per == 0) begin
                    nf = a; nr = a && !m_filt[i]; m_pc[i] = 0; m_dc[i] = 0;
                end else if (m_pc[i] == int'(filt_per) - 1) begin
                    m_pc[i] = 0;
                    if (a == m_filt[i]) m_dc[i] = 0;
                    else if (m_dc[i] == int'(filt_cnt) + 2) begin
                        nf = a; nr = a; m_dc[i] = 0;
                    end else m_dc[i] = m_dc[i] + 1;
                end else m_pc[i] = m_pc[i] + 1;
                m_filt[i] = nf; m_rise[i] = nr;
            end
        end
    end

    // boundary ticks from a free-running PWM-cycle counter
    always @(negedge clk) begin
        tcnt <= tcnt + 1;
        half_tick <= (tcnt % 16 == 3);
        full_tick <= (tcnt % 16 == 11);
    end

    task automatic chk(string tag, logic actual, logic expected);
        n_chk++;
        if (actual !== expected) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        #4;
        if (rst_n && cmp_on) begin
            bit ei;
            ei = 0;
            for (int i = 0; i < N; i++) begin
                chk({phase, " out_dis"}, out_dis[i], (m_st[i] != 0) || (raw_en[i] && act_of(i)));
                chk({phase, " flag"}, flt_flag[i], m_flag[i]);
                if (m_flag[i] && irq_en[i]) ei = 1;
            end
            chk({phase, " irq R5"}, irq, ei);
        end
    end

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clr_pulse(logic [N-1:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5a17));
        flt_pol = 2'b01;
        flt_in  = 2'b10;
        cyc(3);
        #2;
        chk("R12 out_dis", |out_dis, 1'b0);
        chk("R12 flag", |flt_flag, 1'b0);
        chk("R12 irq", irq, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        cmp_on = 1'b1;
        cyc(3);

        // R1 / R2 / R6: bypassed filter, automatic clearing, full-cycle recovery
        phase = "R6";
        @(negedge clk); flt_in = 2'b11;
        cyc(2); #2;
        chk("R1 active-high channel latched", out_dis[0], 1'b1);
        chk("R1 active-low channel idle", out_dis[1], 1'b0);
        chk("R2 bypass flag after two clocks", flt_flag[0], 1'b1);
        cyc(4);
        @(negedge clk); flt_in = 2'b10;
        cyc(40); #2;
        chk("R6 auto release", out_dis[0], 1'b0);
        clr_pulse(2'b11);
        cyc(2); #2;
        chk("R4 cleared flag", flt_flag[0], 1'b0);

        // R3: period 3, count 1 -> four agreeing samples needed
        phase = "R3";
        @(negedge clk); filt_per = 8'd3; filt_cnt = 3'd1;
        cyc(4);
        @(negedge clk); flt_in[0] = 1'b1;
        cyc(5); #2;
        chk("R3 short pulse rejected", flt_flag[0], 1'b0);
        @(negedge clk); flt_in[0] = 1'b0;
        cyc(20); #2;
        chk("R3 no flag after short pulse", flt_flag[0], 1'b0);
        @(negedge clk); flt_in[0] = 1'b1;
        cyc(20); #2;
        chk("R3 long pulse accepted", flt_flag[0], 1'b1);
        @(negedge clk); filt_per = 8'd0;
        @(negedge clk); flt_in[0] = 1'b0;
        cyc(3);
        clr_pulse(2'b11);
        cyc(40);

        // R7: manual without safety, release while input still active
        phase = "R7";
        @(negedge clk); flt_auto = 2'b00; flt_safe = 2'b00; rcv_half = 2'b11; rcv_full = 2'b00;
        @(negedge clk); flt_in[0] = 1'b1;
        cyc(30); #2;
        chk("R7 held until flag cleared", out_dis[0], 1'b1);
        clr_pulse(2'b01);
        cyc(30); #2;
        chk("R7 released with input active", out_dis[0], 1'b0);
        @(negedge clk); flt_in[0] = 1'b0;
        cyc(5);

        // R8: safe manual, needs flag clear and input inactive
        phase = "R8";
        @(negedge clk); flt_safe = 2'b11;
        @(negedge clk); flt_in[0] = 1'b1;
        cyc(3);
        clr_pulse(2'b01);
        cyc(40); #2;
        chk("R8 held while input active", out_dis[0], 1'b1);
        @(negedge clk); flt_in[0] = 1'b0;
        cyc(40); #2;
        chk("R8 released after both conditions", out_dis[0], 1'b1 & 1'b0);

        // R10 then R9: no recovery holds, re-enabling recovery releases
        phase = "R10";
        @(negedge clk); flt_auto = 2'b11; rcv_half = 2'b00; rcv_full = 2'b00;
        @(negedge clk); flt_in[0] = 1'b1;
        cyc(4);
        @(negedge clk); flt_in[0] = 1'b0;
        cyc(60); #2;
        chk("R10 stays disabled without recovery", out_dis[0], 1'b1);
        phase = "R9";
        @(negedge clk); rcv_half = 2'b11;
        cyc(30); #2;
        chk("R9 half-cycle release", out_dis[0], 1'b0);
        clr_pulse(2'b11);

        // R11: raw path with a slow filter
        phase = "R11";
        @(negedge clk); filt_per = 8'd20; raw_en = 2'b01;
        @(negedge clk); flt_in[0] = 1'b1;
        #2;
        chk("R11 raw disable same cycle", out_dis[0], 1'b1);
        chk("R11 flag not yet set", flt_flag[0], 1'b0);
        @(negedge clk); flt_in[0] = 1'b0;
        @(negedge clk); filt_per = 8'd0;
        cyc(5);

        // R5: interrupt enable gating
        phase = "R5";
        @(negedge clk); flt_in[1] = 1'b0; irq_en = 2'b10;
        cyc(4); #2;
        chk("R5 irq with enable", irq, 1'b1);
        @(negedge clk); irq_en = 2'b00;
        #2;
        chk("R5 irq masked", irq, 1'b0);
        @(negedge clk); flt_in[1] = 1'b1;
        cyc(3);

        // random mix: modes, filter settings, inputs, clears (R4 onset/clear race included)
        phase = "R4";
        for (int blk = 0; blk < 15; blk++) begin
            @(negedge clk);
            filt_per = 8'd0;
            flt_auto = 2'($urandom);
            flt_safe = 2'($urandom);
            raw_en   = 2'($urandom);
            rcv_half = 2'($urandom);
            rcv_full = 2'($urandom);
            irq_en   = 2'($urandom);
            flt_pol  = 2'($urandom);
            @(negedge clk);
            filt_per = 8'($urandom_range(0, 3));
            filt_cnt = 3'($urandom_range(0, 2));
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if ($urandom_range(0, 9) == 0) flt_in = 2'($urandom);
                flag_clr = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            end
            flag_clr = '0;
        end

        cyc(2);
        done = 1'b1;
        finish_run();
    end
endmodule